// File: doc/BRIEF.md
# Interlock-Aware Parcel Buffer Stack

This block sits between an incoming parcel highway and an outgoing processor highway and smooths out differences in flow rate between them. A parcel is a bundle of three fields: an instruction word, a flow operand and a static operand. When the pipeline interlock is low, each valid parcel goes straight from input to output in the same cycle, with no register on the way.

While the interlock is high, valid parcels are pushed onto a small last-in first-out store instead of being forwarded. Stored parcels drain one per cycle, newest first. A parcel drains only in a cycle where the input carries nothing and the output is ready. Parcels that carry the I/O-or-cache marker are discarded and are never stored or forwarded. A push into a full store loses that parcel and sets a sticky overflow flag. Only reset clears the flag.

Top module: `parcel_lifo_bypass`

## Requirements
- R1: With `interlock` low and `in_valid` high and `in_special` low, `out_valid` is high in the same cycle and the three output fields equal the three input fields.
- R2: With `interlock` high and `in_valid` high and `in_special` low, `out_valid` is low in that cycle and the parcel is stored for later issue.
- R3: A stored parcel appears on the output, with `out_valid` high, only in a cycle where `in_valid` is low and `out_ready` is high. The level of `interlock` does not affect this. The parcel leaves the store at the end of that cycle.
- R4: Stored parcels issue in last-in first-out order.
- R5: A parcel with `in_valid` high and `in_special` high never reaches the output and is never stored. The input still counts as occupied in that cycle, so no stored parcel drains.
- R6: The store holds `DEPTH` parcels (default 4). A push into a full store drops the new parcel, leaves the stored parcels unchanged and sets `overflow`. Once set, `overflow` stays high until reset.
- R7: When a pass-through parcel arrives while the store is not empty, the output carries the incoming parcel and every stored parcel is kept.
- R8: After reset the store is empty and `overflow` is low. With no input, `out_valid` is low.
- R9: With `in_valid` low and `out_ready` low, `out_valid` is low and no stored parcel is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| interlock | input | 1 | Pipeline hold; valid input parcels are stored while it is high |
| in_valid | input | 1 | Input parcel present |
| in_special | input | 1 | Input parcel carries the I/O-or-cache marker (1 = discard) |
| in_insn | input | INSN_W | Input instruction word |
| in_flow | input | OPND_W | Input flow operand |
| in_static | input | OPND_W | Input static operand |
| out_ready | input | 1 | Output highway is clear |
| out_valid | output | 1 | Output parcel present |
| out_insn | output | INSN_W | Output instruction word |
| out_flow | output | OPND_W | Output flow operand |
| out_static | output | OPND_W | Output static operand |
| overflow | output | 1 | Sticky flag: a push found the store full |

## Verification
Several properties are checked on every cycle:
- the same-cycle pass-through and its field equality;
- silence of the output while the interlock holds or a marked parcel arrives;
- no issue from the store without `out_ready`;
- stickiness of the overflow flag and its cause;
- the rule that a push and a pop never happen together.

Some behaviours only the directed scenarios can show, because they depend on what was stored earlier:
- the newest-first drain order;
- survival of stored parcels across a pass-through or a marked input;
- loss of exactly the parcel that found the store full.

// File: rtl/pbuf_pkg.sv
// Shared types for the parcel buffer stack.
// Assumes: used by pbuf_route and parcel_lifo_bypass.
package pbuf_pkg;

    // Per-cycle routing decision for the incoming and stored parcels.
    typedef enum logic [2:0] {
        RT_IDLE = 3'd0,   // nothing moves
        RT_PASS = 3'd1,   // input goes straight to output
        RT_PUSH = 3'd2,   // input is stored (or dropped if full)
        RT_POP  = 3'd3,   // newest stored parcel goes to output
        RT_DROP = 3'd4    // marked input is discarded
    } route_e;

endpackage

// File: rtl/pbuf_route.sv
// Routing decision for the parcel buffer stack.
// Picks, each cycle, between pass-through, store, drain, discard and idle.
// Assumes: full/empty come from the store in the same cycle; purely combinational.
module pbuf_route
    import pbuf_pkg::*;
(
    input  logic   in_valid,
    input  logic   in_special,
    input  logic   interlock,
    input  logic   out_ready,
    input  logic   empty,
    input  logic   full,
    output route_e act,
    output logic   do_push,
    output logic   do_pop,
    output logic   ovf_hit
);

    // Decide what happens this cycle; any present input blocks draining.
    always_comb begin
        act = RT_IDLE;
        if (in_valid) begin
            if (in_special)     act = RT_DROP;
            else if (interlock) act = RT_PUSH;
            else                act = RT_PASS;
        end else if (out_ready && !empty) begin
            act = RT_POP;
        end
    end

    // Turn the decision into store commands and the overflow event.
    always_comb begin
        do_push = (act == RT_PUSH) && !full;
        do_pop  = (act == RT_POP);
        ovf_hit = (act == RT_PUSH) && full;
    end

endmodule

// File: rtl/pbuf_lifo.sv
// Last-in first-out parcel store of DEPTH entries.
// Presents the newest entry combinationally; push writes above it, pop removes it.
// Assumes: the caller never pushes when full, never pops when empty,
// and never does both in one cycle.
module pbuf_lifo #(
    parameter int W     = 96,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] cnt;
    logic [W-1:0]  mem [DEPTH];

    // Occupancy counter: up on push, down on pop, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (push) cnt <= cnt + 1'b1;
        else if (pop)  cnt <= cnt - 1'b1;
    end

    // One write port per entry slot, selected by the current occupancy.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && (cnt == CW'(g))) mem[g] <= wdata;
        end
    end

    // Select the newest entry (slot cnt-1) for the read side.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cnt == CW'(i + 1)) rdata = mem[i];
        end
    end

    // Derive the occupancy flags.
    always_comb begin
        empty = (cnt == '0);
        full  = (cnt == CW'(DEPTH));
    end

    // R3: a push and a pop are never requested together.
    a_r3_no_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
    // R6: the router never pushes into a full store.
    a_r6_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full));
    // R2: after a push the store is non-empty.
    a_r2_push_fills: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !empty);
    // R3: a pop frees at least one slot.
    a_r3_pop_frees: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !full);

endmodule

// File: rtl/parcel_lifo_bypass.sv
// Parcel buffer stack between an input highway and the processor highway.
// Forwards parcels in the same cycle when not interlocked.
// Stores them newest-first while interlocked, and drains the store only in idle input cycles.
// Discards marked parcels and flags pushes into a full store.
// Assumes: synchronous active-low reset; out_ready governs draining only.
module parcel_lifo_bypass
    import pbuf_pkg::*;
#(
    parameter int INSN_W = 32,
    parameter int OPND_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              interlock,
    input  logic              in_valid,
    input  logic              in_special,
    input  logic [INSN_W-1:0] in_insn,
    input  logic [OPND_W-1:0] in_flow,
    input  logic [OPND_W-1:0] in_static,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [INSN_W-1:0] out_insn,
    output logic [OPND_W-1:0] out_flow,
    output logic [OPND_W-1:0] out_static,
    output logic              overflow
);

    localparam int PW = INSN_W + 2 * OPND_W;

    route_e        act;
    logic          do_push, do_pop, ovf_hit;
    logic          empty, full;
    logic [PW-1:0] in_parcel, top_parcel, sel_parcel;
    logic          ovf_q;

    assign in_parcel = {in_insn, in_flow, in_static};

    pbuf_route u_route (
        .in_valid   (in_valid),
        .in_special (in_special),
        .interlock  (interlock),
        .out_ready  (out_ready),
        .empty      (empty),
        .full       (full),
        .act        (act),
        .do_push    (do_push),
        .do_pop     (do_pop),
        .ovf_hit    (ovf_hit)
    );

    pbuf_lifo #(.W(PW), .DEPTH(DEPTH)) u_lifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (do_push),
        .pop   (do_pop),
        .wdata (in_parcel),
        .rdata (top_parcel),
        .empty (empty),
        .full  (full)
    );

    // Output mux: the incoming parcel when passing through, else the stored top.
    always_comb begin
        out_valid  = (act == RT_PASS) || (act == RT_POP);
        sel_parcel = (act == RT_PASS) ? in_parcel : top_parcel;
        {out_insn, out_flow, out_static} = sel_parcel;
    end

    // Sticky overflow flag, set by a push into a full store.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_q <= 1'b0;
        else if (ovf_hit) ovf_q <= 1'b1;
    end
    assign overflow = ovf_q;

    // R1: an unmarked parcel without interlock appears unchanged in the same cycle.
    a_r1_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_special && !interlock) |->
        (out_valid && out_insn == in_insn && out_flow == in_flow && out_static == in_static));
    // R2: nothing leaves while an input parcel is held by the interlock.
    a_r2_held_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && interlock) |-> !out_valid);
    // R5: a marked parcel never yields output.
    a_r5_special_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_special) |-> !out_valid);
    // R9: no drain unless the output highway is clear.
    a_r9_wait_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !out_ready) |-> !out_valid);
    // R6: once raised, overflow stays raised.
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    // R6: overflow rises only after an interlocked unmarked input.
    a_r6_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(in_valid && interlock && !in_special));

endmodule

// File: tb/test_parcel_lifo_bypass.sv
`timescale 1ns/1ps
// Directed bench for parcel_lifo_bypass: one task per scenario.
module test_parcel_lifo_bypass;

    localparam int INSN_W = 32;
    localparam int OPND_W = 32;
    localparam int DEPTH  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              interlock = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_special = 1'b0;
    logic [INSN_W-1:0] in_insn = '0;
    logic [OPND_W-1:0] in_flow = '0;
    logic [OPND_W-1:0] in_static = '0;
    logic              out_ready = 1'b0;
    logic              out_valid;
    logic [INSN_W-1:0] out_insn;
    logic [OPND_W-1:0] out_flow;
    logic [OPND_W-1:0] out_static;
    logic              overflow;

    int n_chk = 0;
    int n_bad = 0;

    parcel_lifo_bypass #(.INSN_W(INSN_W), .OPND_W(OPND_W), .DEPTH(DEPTH)) i_parcel_lifo_bypass (
        .clk(clk), .rst_n(rst_n), .interlock(interlock),
        .in_valid(in_valid), .in_special(in_special),
        .in_insn(in_insn), .in_flow(in_flow), .in_static(in_static),
        .out_ready(out_ready), .out_valid(out_valid),
        .out_insn(out_insn), .out_flow(out_flow), .out_static(out_static),
        .overflow(overflow)
    );

    always #2.5 clk = ~clk;

    function automatic logic [INSN_W-1:0] p_insn(int k);
        return 32'hA100_0000 + k;
    endfunction
    function automatic logic [OPND_W-1:0] p_flow(int k);
        return 32'h0F00_0000 + (k * 3);
    endfunction
    function automatic logic [OPND_W-1:0] p_stat(int k);
        return 32'h5000_0000 ^ (k << 4);
    endfunction

    // Wait for the falling edge, apply inputs, let combinational outputs settle.
    task automatic drive(input logic v, input logic sp, input logic il, input logic rdy, input int k);
        @(negedge clk);
        in_valid   = v;
        in_special = sp;
        interlock  = il;
        out_ready  = rdy;
        in_insn    = p_insn(k);
        in_flow    = p_flow(k);
        in_static  = p_stat(k);
        #1;
    endtask

    // Compare output valid and, if expected valid, the parcel of index k.
    task automatic expect_out(input string req, input logic ev, input int k);
        n_chk++;
        if (out_valid !== ev) begin
            n_bad++;
            $display("FAIL %s: out_valid=%0b expected %0b", req, out_valid, ev);
        end else if (ev && (out_insn !== p_insn(k) || out_flow !== p_flow(k) || out_static !== p_stat(k))) begin
            n_bad++;
            $display("FAIL %s: parcel %h/%h/%h expected %h/%h/%h", req,
                     out_insn, out_flow, out_static, p_insn(k), p_flow(k), p_stat(k));
        end
    endtask

    task automatic expect_ovf(input string req, input logic ev);
        n_chk++;
        if (overflow !== ev) begin
            n_bad++;
            $display("FAIL %s: overflow=%0b expected %0b", req, overflow, ev);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        drive(1'b0, 1'b0, 1'b0, 1'b1, 0);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 0);
        rst_n = 1'b1;
    endtask

    // R8: reset state.
    task automatic t_reset();
        do_reset();
        drive(1'b0, 1'b0, 1'b0, 1'b1, 0);
        expect_out("R8 empty after reset", 1'b0, 0);
        expect_ovf("R8 overflow clear", 1'b0);
    endtask

    // R1: same-cycle pass-through for several parcels.
    task automatic t_pass();
        for (int k = 1; k <= 4; k++) begin
            drive(1'b1, 1'b0, 1'b0, k[0], k);
            expect_out("R1 pass-through", 1'b1, k);
        end
        drive(1'b0, 1'b0, 1'b0, 1'b1, 0);
        expect_out("R1 nothing stored by pass", 1'b0, 0);
    endtask

    // R2, R9, R3, R4: store under interlock, hold without ready, drain newest first.
    task automatic t_push_drain();
        for (int k = 20; k < 23; k++) begin
            drive(1'b1, 1'b0, 1'b1, 1'b1, k);
            expect_out("R2 held under interlock", 1'b0, 0);
        end
        drive(1'b0, 1'b0, 1'b0, 1'b0, 0);
        expect_out("R9 no drain without ready", 1'b0, 0);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 0);
        expect_out("R3 drain while interlocked", 1'b1, 22);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 0);
        expect_out("R4 second newest", 1'b1, 21);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 0);
        expect_out("R4 oldest last", 1'b1, 20);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 0);
        expect_out("R3 store empty after drain", 1'b0, 0);
    endtask

    // R7: pass-through wins over a waiting stored parcel.
    task automatic t_priority();
        drive(1'b1, 1'b0, 1'b1, 1'b1, 30);
        drive(1'b1, 1'b0, 1'b0, 1'b1, 31);
        expect_out("R7 pass-through wins", 1'b1, 31);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 0);
        expect_out("R7 stored parcel kept", 1'b1, 30);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 0);
        expect_out("R7 store empty", 1'b0, 0);
    endtask

    // R5: marked parcels are neither forwarded nor stored, and block draining.
    task automatic t_special();
        drive(1'b1, 1'b1, 1'b0, 1'b1, 40);
        expect_out("R5 marked not forwarded", 1'b0, 0);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 41);
        expect_out("R5 marked under interlock", 1'b0, 0);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 0);
        expect_out("R5 marked not stored", 1'b0, 0);
        drive(1'b1, 1'b0, 1'b1, 1'b1, 42);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 43);
        expect_out("R5 marked input blocks drain", 1'b0, 0);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 0);
        expect_out("R5 stored parcel survives", 1'b1, 42);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 0);
        expect_out("R5 store empty", 1'b0, 0);
    endtask

    // R6, R8: fill past depth, drop the extra parcel, sticky flag, reset clears it.
    task automatic t_overflow();
        for (int k = 0; k < DEPTH; k++) begin
            drive(1'b1, 1'b0, 1'b1, 1'b1, 50 + k);
        end
        drive(1'b1, 1'b0, 1'b1, 1'b1, 50 + DEPTH);
        expect_ovf("R6 flag low before full push lands", 1'b0);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 0);
        expect_ovf("R6 flag set by push into full store", 1'b1);
        for (int k = DEPTH - 1; k >= 0; k--) begin
            drive(1'b0, 1'b0, 1'b0, 1'b1, 0);
            expect_out("R6 stored parcels intact", 1'b1, 50 + k);
        end
        drive(1'b0, 1'b0, 1'b0, 1'b1, 0);
        expect_out("R6 dropped parcel absent", 1'b0, 0);
        expect_ovf("R6 flag sticky", 1'b1);
        do_reset();
        drive(1'b0, 1'b0, 1'b0, 1'b1, 0);
        expect_ovf("R8 reset clears overflow", 1'b0);
    endtask

    initial begin
        t_reset();
        t_pass();
        t_push_drain();
        t_priority();
        t_special();
        t_overflow();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule